// File: doc/BRIEF.md
# Configurable Serial Audio Frame Transmitter

This block turns 32-bit sample words into a serial audio stream made of a bit clock, a frame sync and one data line. Samples enter through a 32-entry transmit FIFO. A small register write port sets the frame format: how many words make up a frame, the widths of the first word and of the later words, which bit of each FIFO word goes out first, and the length, polarity and early timing of the frame sync. The bit clock is derived from the block clock through an even divider. Data is shifted out most significant bit first, changes at the start of each bit period and is stable on the active bit clock edge, which falls in the middle of the period.

A DMA request output tells a transfer engine to refill the FIFO. It is active while the FIFO level is at or below a programmable watermark. When a word is due and the FIFO is empty, zeros go out for that word and a sticky error flag is set. The flag can drive an interrupt output and is cleared by writing a one.

Top module: `audio_frame_tx`

## Requirements
- R1: After reset, dma_req, err_flag, irq, sclk_o, sclk_oe, fs_o, sd_o and fifo_full are all 0, and every register field is 0.
- R2: The clock register (address 1) holds the divide value `div` in bits [7:0] and the clock invert bit in bit 8. While transmitting with bit clock enable set, sclk_o has a period of (div+1)*2 clk cycles. When not transmitting, sclk_o rests at the value of the invert bit, and the invert bit inverts the whole waveform.
- R3: sclk_oe follows clock register bit 9 and fs_oe follows frame register (address 2) bit 18.
- R4: The word register (address 3) holds the first word width minus one in bits [4:0] and the later word width minus one in bits [12:8]. The frame register holds the number of words per frame minus one in bits [4:0]. FIFO words are consumed in order, one per word slot, beginning with word 0 of each frame.
- R5: Word register bits [20:16] give the index `fb` of the first bit sent. Bit k of a slot (k = 0 first) carries word bit fb-k, or 0 when k > fb.
- R6: Frame register bits [12:8] hold the sync width minus one, `sw`. With the early bit (frame register bit 16) clear, frame sync is active during frame bit positions 0 through sw.
- R7: With the early bit set, the sync pulse moves one bit earlier: it is active at the last bit of the previous frame and at positions 0 through sw-1. Frame register bit 17 makes fs_o active low, and fs_o rests at the inactive level while idle.
- R8: The FIFO holds 32 words. fifo_full is 1 at 32 entries and 0 below that, and a push while full is discarded.
- R9: The watermark register (address 4) holds a 5-bit level `wm`. dma_req is 1 exactly when the DMA enable bit (control bit 2) is set and the FIFO level is at most wm.
- R10: Control register (address 0) bit 0 enables transmission and bit 1 enables the bit clock. When a word slot begins while the FIFO is empty, that slot carries zeros and err_flag becomes 1 and stays 1. irq equals err_flag ANDed with control bit 3.
- R11: A control write with bit 8 set clears err_flag. A control write with bit 8 clear leaves it unchanged.
- R12: While control bit 0 is set, writes to addresses 1 to 4 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the source of the bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Register write data |
| push_valid | input | 1 | Push one word into the FIFO |
| push_data | input | 32 | Word to push |
| fifo_full | output | 1 | FIFO holds 32 words |
| dma_req | output | 1 | Refill request, level at or below the watermark |
| err_flag | output | 1 | Sticky underrun flag |
| irq | output | 1 | Error interrupt |
| sclk_o | output | 1 | Bit clock |
| sclk_oe | output | 1 | Bit clock output enable |
| fs_o | output | 1 | Frame sync |
| fs_oe | output | 1 | Frame sync output enable |
| sd_o | output | 1 | Serial data |

## Verification
The hardest case to reach from the ports is a word slot that starts with an empty FIFO in the middle of a frame, because the transmitter normally stops before the data runs out. The stimulus loads a single word into a two-word frame, turns the transmitter on and captures the frame through a receiver model. That receiver samples sd_o on the active bit clock edge, so the zero-filled second slot and the err_flag that follows can both be checked. Clearing the flag is then tried with a control write that leaves bit 8 clear and again with one that sets it.

// File: rtl/aft_pkg.sv
package aft_pkg;

  localparam int IDX_W = 5;
  localparam int POS_W = 11;
  localparam int DIV_W = 8;

  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_CLK   = 3'd1;
  localparam logic [2:0] A_FRAME = 3'd2;
  localparam logic [2:0] A_WORD  = 3'd3;
  localparam logic [2:0] A_WMARK = 3'd4;

  typedef struct packed {
    logic err_ie;
    logic dma_en;
    logic bclk_en;
    logic tx_en;
  } ctrl_t;

  typedef struct packed {
    logic             bclk_drive;
    logic             bclk_inv;
    logic [DIV_W-1:0] div;
  } clkcfg_t;

  typedef struct packed {
    logic             fs_drive;
    logic             fs_low;
    logic             early;
    logic [IDX_W-1:0] sync_m1;
    logic [IDX_W-1:0] words_m1;
  } framecfg_t;

  typedef struct packed {
    logic [IDX_W-1:0] first_bit;
    logic [IDX_W-1:0] wn_m1;
    logic [IDX_W-1:0] w0_m1;
  } wordcfg_t;

  // bit clock period in clk cycles: twice (div + 1)
  function automatic logic [DIV_W+1:0] bclk_period(input logic [DIV_W-1:0] d);
    return ({2'b00, d} + 1'b1) << 1;
  endfunction

  // number of bit clocks in one frame
  function automatic logic [POS_W-1:0] frame_len(input framecfg_t f, input wordcfg_t w);
    logic [POS_W-1:0] first, rest;
    first = POS_W'(w.w0_m1) + 1'b1;
    rest  = POS_W'(f.words_m1) * (POS_W'(w.wn_m1) + 1'b1);
    return first + rest;
  endfunction

  // frame sync level (active high) at a given frame bit position
  function automatic logic sync_active(input logic [POS_W-1:0] pos,
                                       input logic [POS_W-1:0] len,
                                       input framecfg_t f);
    logic [POS_W-1:0] p;
    p = pos;
    if (f.early) p = (pos == len - 1'b1) ? '0 : pos + 1'b1;
    return p <= POS_W'(f.sync_m1);
  endfunction

  // data bit for slot bit k, counting down from the first bit index
  function automatic logic pick_bit(input logic [31:0] word,
                                    input logic [IDX_W-1:0] fb,
                                    input logic [IDX_W-1:0] k);
    if (k > fb) return 1'b0;
    return word[fb - k];
  endfunction

endpackage

// File: rtl/aft_regs.sv
module aft_regs
  import aft_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output ctrl_t             ctrl,
  output clkcfg_t           clkcfg,
  output framecfg_t         framecfg,
  output wordcfg_t          wordcfg,
  output logic [IDX_W-1:0]  wmark,
  output logic              err_clr
);

  logic unused_wdata;
  assign unused_wdata = ^wdata;

  logic locked;
  assign locked = ctrl.tx_en;

  logic hit_ctrl, hit_clk, hit_frame, hit_word, hit_wmark;
  assign hit_ctrl  = we && (addr == ADDR_W'(A_CTRL));
  assign hit_clk   = we && !locked && (addr == ADDR_W'(A_CLK));
  assign hit_frame = we && !locked && (addr == ADDR_W'(A_FRAME));
  assign hit_word  = we && !locked && (addr == ADDR_W'(A_WORD));
  assign hit_wmark = we && !locked && (addr == ADDR_W'(A_WMARK));

  assign err_clr = hit_ctrl && wdata[8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl     <= '0;
      clkcfg   <= '0;
      framecfg <= '0;
      wordcfg  <= '0;
      wmark    <= '0;
    end else begin
      if (hit_ctrl) begin
        ctrl.tx_en   <= wdata[0];
        ctrl.bclk_en <= wdata[1];
        ctrl.dma_en  <= wdata[2];
        ctrl.err_ie  <= wdata[3];
      end
      if (hit_clk) begin
        clkcfg.div        <= wdata[DIV_W-1:0];
        clkcfg.bclk_inv   <= wdata[8];
        clkcfg.bclk_drive <= wdata[9];
      end
      if (hit_frame) begin
        framecfg.words_m1 <= wdata[4:0];
        framecfg.sync_m1  <= wdata[12:8];
        framecfg.early    <= wdata[16];
        framecfg.fs_low   <= wdata[17];
        framecfg.fs_drive <= wdata[18];
      end
      if (hit_word) begin
        wordcfg.w0_m1     <= wdata[4:0];
        wordcfg.wn_m1     <= wdata[12:8];
        wordcfg.first_bit <= wdata[20:16];
      end
      if (hit_wmark) wmark <= wdata[4:0];
    end
  end

endmodule

// File: rtl/aft_fifo.sv
module aft_fifo #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic [LVL_W-1:0]  level,
  output logic              empty,
  output logic              full
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wp, rp;

  logic do_push, do_pop;
  assign full    = (level == LVL_W'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rp];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop)  rp <= bump(rp);
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/aft_bitclk.sv
module aft_bitclk
  import aft_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             phase_hi,
  output logic             bit_adv
);

  localparam int CNT_W = DIV_W + 2;

  logic [CNT_W-1:0] cnt, period, half;
  assign period = bclk_period(div);
  assign half   = CNT_W'(div) + 1'b1;

  assign bit_adv  = run && (cnt == period - 1'b1);
  assign phase_hi = run && (cnt >= half);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (bit_adv)   cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/aft_framer.sv
module aft_framer
  import aft_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              bit_adv,
  input  framecfg_t         framecfg,
  input  wordcfg_t          wordcfg,
  input  logic [DATA_W-1:0] fifo_head,
  input  logic              fifo_empty,
  output logic              run,
  output logic              word_load,
  output logic              pop,
  output logic              underrun_evt,
  output logic              sd,
  output logic              fs_act
);

  logic [POS_W-1:0]  bitpos, len;
  logic [IDX_W-1:0]  bit_in_word, word_idx, cur_w_m1;
  logic [DATA_W-1:0] cur_word, next_word;
  logic              end_of_word, end_of_frame;

  assign len          = frame_len(framecfg, wordcfg);
  assign cur_w_m1     = (word_idx == '0) ? wordcfg.w0_m1 : wordcfg.wn_m1;
  assign end_of_word  = (bit_in_word == cur_w_m1);
  assign end_of_frame = end_of_word && (word_idx == framecfg.words_m1);

  assign word_load    = tx_en && (!run || (bit_adv && end_of_word));
  assign pop          = word_load && !fifo_empty;
  assign underrun_evt = word_load && fifo_empty;
  assign next_word    = fifo_empty ? '0 : fifo_head;

  assign sd     = run && pick_bit(cur_word, wordcfg.first_bit, bit_in_word);
  assign fs_act = run && sync_active(bitpos, len, framecfg);

  always_ff @(posedge clk) begin
    if (!rst_n || !tx_en) begin
      run         <= 1'b0;
      bitpos      <= '0;
      bit_in_word <= '0;
      word_idx    <= '0;
      cur_word    <= '0;
    end else if (!run) begin
      run         <= 1'b1;
      bitpos      <= '0;
      bit_in_word <= '0;
      word_idx    <= '0;
      cur_word    <= next_word;
    end else if (bit_adv) begin
      if (end_of_frame) begin
        bitpos      <= '0;
        word_idx    <= '0;
        bit_in_word <= '0;
      end else if (end_of_word) begin
        bitpos      <= bitpos + 1'b1;
        word_idx    <= word_idx + 1'b1;
        bit_in_word <= '0;
      end else begin
        bitpos      <= bitpos + 1'b1;
        bit_in_word <= bit_in_word + 1'b1;
      end
      if (end_of_word) cur_word <= next_word;
    end
  end

endmodule

// File: rtl/audio_frame_tx.sv
module audio_frame_tx
  import aft_pkg::*;
#(
  parameter int FIFO_DEPTH = 32,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 3,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  output logic              fifo_full,
  output logic              dma_req,
  output logic              err_flag,
  output logic              irq,
  output logic              sclk_o,
  output logic              sclk_oe,
  output logic              fs_o,
  output logic              fs_oe,
  output logic              sd_o
);

  ctrl_t            ctrl;
  clkcfg_t          clkcfg;
  framecfg_t        framecfg;
  wordcfg_t         wordcfg;
  logic [IDX_W-1:0] wmark;
  logic             err_clr;

  // named internal events, observed by the checker
  logic              run, bit_adv, phase_hi, word_load, pop, underrun_evt;
  logic              fifo_empty, fs_act, sd_int;
  logic [DATA_W-1:0] fifo_head;
  logic [LVL_W-1:0]  fifo_level;

  aft_regs #(.ADDR_W(ADDR_W), .DATA_W(32)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .ctrl(ctrl), .clkcfg(clkcfg), .framecfg(framecfg), .wordcfg(wordcfg),
    .wmark(wmark), .err_clr(err_clr)
  );

  aft_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(DATA_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push_valid), .push_data(push_data),
    .pop(pop), .head(fifo_head), .level(fifo_level), .empty(fifo_empty),
    .full(fifo_full)
  );

  aft_bitclk u_bclk (
    .clk(clk), .rst_n(rst_n), .run(run), .div(clkcfg.div),
    .phase_hi(phase_hi), .bit_adv(bit_adv)
  );

  aft_framer #(.DATA_W(DATA_W)) u_framer (
    .clk(clk), .rst_n(rst_n), .tx_en(ctrl.tx_en), .bit_adv(bit_adv),
    .framecfg(framecfg), .wordcfg(wordcfg), .fifo_head(fifo_head),
    .fifo_empty(fifo_empty), .run(run), .word_load(word_load), .pop(pop),
    .underrun_evt(underrun_evt), .sd(sd_int), .fs_act(fs_act)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)            err_flag <= 1'b0;
    else if (underrun_evt) err_flag <= 1'b1;
    else if (err_clr)      err_flag <= 1'b0;
  end

  assign irq     = err_flag && ctrl.err_ie;
  assign dma_req = ctrl.dma_en && (fifo_level <= LVL_W'(wmark));
  assign sclk_o  = (phase_hi && ctrl.bclk_en) ^ clkcfg.bclk_inv;
  assign sclk_oe = clkcfg.bclk_drive;
  assign fs_o    = fs_act ^ framecfg.fs_low;
  assign fs_oe   = framecfg.fs_drive;
  assign sd_o    = sd_int;

endmodule

// File: rtl/aft_checker.sv
module aft_checker #(
  parameter int DEPTH = 32,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_en,
  input logic             run,
  input logic             bit_adv,
  input logic             underrun_evt,
  input logic             err_clr,
  input logic             err_flag,
  input logic             pop,
  input logic             fifo_full,
  input logic [LVL_W-1:0] fifo_level,
  input logic             sd_o,
  input logic             fs_o,
  input logic             fs_low,
  input logic [14:0]      word_bits
);

  // R12: format registers frozen while transmitting
  a_r12_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && $past(tx_en)) |-> $stable(word_bits));

  // R10: an underrun raises the error flag on the next cycle
  a_r10_underrun_flags: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_evt |=> err_flag);

  // R10: the error flag holds until cleared
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clr) |=> err_flag);

  // R8: the level never exceeds the depth
  a_r8_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LVL_W'(DEPTH));

  // R8: a full FIFO without a pop keeps its level
  a_r8_full_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && !pop) |=> $stable(fifo_level));

  // R5: data only changes after a bit boundary
  a_r5_sd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$past(bit_adv)) |-> $stable(sd_o));

  // R7: frame sync rests at its inactive level when idle
  a_r7_fs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (fs_o == fs_low));

endmodule

bind audio_frame_tx aft_checker #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(ctrl.tx_en), .run(run), .bit_adv(bit_adv),
  .underrun_evt(underrun_evt), .err_clr(err_clr), .err_flag(err_flag),
  .pop(pop), .fifo_full(fifo_full), .fifo_level(fifo_level), .sd_o(sd_o),
  .fs_o(fs_o), .fs_low(framecfg.fs_low), .word_bits(wordcfg)
);

// File: tb/sim_audio_frame_tx.sv
module sim_audio_frame_tx;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        push_valid = 1'b0;
  logic [31:0] push_data = '0;
  logic fifo_full, dma_req, err_flag, irq, sclk_o, sclk_oe, fs_o, fs_oe, sd_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [31:0] wq [8];
  int          nwq;
  bit exp_sd [128], exp_fs [128], got_sd [128], got_fs [128];
  int gap;

  always #(CLK_P/2) clk = ~clk;

  audio_frame_tx u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .push_valid(push_valid), .push_data(push_data),
    .fifo_full(fifo_full), .dma_req(dma_req), .err_flag(err_flag), .irq(irq),
    .sclk_o(sclk_o), .sclk_oe(sclk_oe), .fs_o(fs_o), .fs_oe(fs_oe), .sd_o(sd_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic push(input logic [31:0] d);
    @(negedge clk); push_valid = 1'b1; push_data = d;
    @(negedge clk); push_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // receiver model: records sd/fs on each active bit clock edge
  task automatic collect(input int n, input bit inv);
    int got = 0, cyc = 0, last = -1;
    bit prev, s;
    prev = sclk_o ^ inv;
    while (got < n) begin
      @(negedge clk);
      cyc++;
      s = sclk_o ^ inv;
      if (s && !prev) begin
        got_sd[got] = sd_o;
        got_fs[got] = fs_o;
        if (last >= 0) gap = cyc - last;
        last = cyc;
        got++;
      end
      prev = s;
    end
  endtask

  // expected stream from the frame format rules
  task automatic build(input int nbits, input int words_m1, input int w0,
                       input int wn, input int fb, input int sw,
                       input bit early, input bit low);
    int len = (w0 + 1) + words_m1 * (wn + 1);
    int idx = 0, wnum = 0;
    while (idx < nbits) begin
      for (int w = 0; w <= words_m1; w++) begin
        int width = (w == 0) ? w0 + 1 : wn + 1;
        logic [31:0] word = (wnum < nwq) ? wq[wnum] : 32'h0;
        for (int k = 0; k < width; k++) begin
          int pos = idx % len;
          int p = early ? ((pos + 1) % len) : pos;
          if (idx < nbits) begin
            exp_sd[idx] = (k > fb) ? 1'b0 : word[fb - k];
            exp_fs[idx] = (p <= sw) ^ low;
          end
          idx++;
        end
        wnum++;
      end
    end
  endtask

  task automatic compare(input int n, input string req_sd, input string req_fs);
    int msd = 0, mfs = 0, first = -1;
    for (int i = 0; i < n; i++) begin
      if (got_sd[i] != exp_sd[i]) begin msd++; if (first < 0) first = i; end
      if (got_fs[i] != exp_fs[i]) mfs++;
    end
    chk(msd == 0, req_sd, "data stream mismatches", msd, 0);
    chk(mfs == 0, req_fs, "sync stream mismatches", mfs, 0);
  endtask

  task automatic stop_tx();
    wr(3'd0, 32'h100);
    idle(4);
    wr(3'd0, 32'h100);
  endtask

  task automatic t_reset();
    idle(1);
    chk(dma_req == 0, "R1", "dma_req", dma_req, 0);
    chk(err_flag == 0 && irq == 0, "R1", "err/irq", err_flag | irq, 0);
    chk(sclk_o == 0 && sclk_oe == 0, "R1", "sclk", sclk_o | sclk_oe, 0);
    chk(fs_o == 0 && sd_o == 0, "R1", "fs/sd", fs_o | sd_o, 0);
    chk(fifo_full == 0, "R1", "fifo_full", fifo_full, 0);
  endtask

  // two 24-bit slots, early active-low 24-bit sync, first bit 31
  task automatic t_stereo();
    wr(3'd1, 32'h201);
    wr(3'd2, 32'h71701);
    wr(3'd3, 32'h1F1717);
    chk(sclk_oe == 1 && fs_oe == 1, "R3", "output enables driven", sclk_oe + fs_oe, 2);
    chk(fs_o == 1, "R7", "idle active-low sync level", fs_o, 1);
    wq[0] = 32'hF0E1D2C3; wq[1] = 32'h12345678;
    wq[2] = 32'h80000001; wq[3] = 32'h5A5AA5A5; nwq = 4;
    for (int i = 0; i < 4; i++) push(wq[i]);
    wr(3'd0, 32'h103);
    collect(96, 1'b0);
    build(96, 1, 23, 23, 31, 23, 1'b1, 1'b1);
    compare(96, "R4", "R7");
    chk(gap == 4, "R2", "bit clock period div=1", gap, 4);
    stop_tx();
  endtask

  // three slots 8/16/16, first bit 11, one-bit sync, inverted clock
  task automatic t_mixed();
    wr(3'd1, 32'h102);
    wr(3'd2, 32'h2);
    wr(3'd3, 32'h0B0F07);
    chk(sclk_oe == 0 && fs_oe == 0, "R3", "output enables off", sclk_oe + fs_oe, 0);
    chk(sclk_o == 1, "R2", "inverted idle clock level", sclk_o, 1);
    wq[0] = 32'h13579BDF; wq[1] = 32'h2468ACE0; wq[2] = 32'hDEADBEEF; nwq = 3;
    for (int i = 0; i < 3; i++) push(wq[i]);
    wr(3'd0, 32'h103);
    wr(3'd3, 32'h1F1F1F);   // R12: must be ignored while enabled
    collect(40, 1'b1);
    build(40, 2, 7, 15, 11, 0, 1'b0, 1'b0);
    compare(40, "R5", "R6");
    chk(gap == 6, "R2", "bit clock period div=2", gap, 6);
    stop_tx();
  endtask

  // R12: the locked write left the word format unchanged; rerun and compare
  task automatic t_lock();
    wq[0] = 32'h00000FA5; wq[1] = 32'h0000F00F; wq[2] = 32'h0000ABCD; nwq = 3;
    for (int i = 0; i < 3; i++) push(wq[i]);
    wr(3'd0, 32'h103);
    collect(40, 1'b1);
    build(40, 2, 7, 15, 11, 0, 1'b0, 1'b0);
    compare(40, "R12", "R12");
    stop_tx();
  endtask

  // one word into a two-slot frame: second slot underruns
  task automatic t_underrun();
    wr(3'd1, 32'h0);
    wr(3'd2, 32'h1);
    wr(3'd3, 32'h070707);
    chk(err_flag == 0, "R10", "flag clear before test", err_flag, 0);
    wq[0] = 32'h000000A5; nwq = 1;
    push(wq[0]);
    wr(3'd0, 32'h10B);
    collect(16, 1'b0);
    build(16, 1, 7, 7, 7, 0, 1'b0, 1'b0);
    compare(16, "R10", "R6");
    idle(2);
    chk(err_flag == 1, "R10", "underrun flag", err_flag, 1);
    chk(irq == 1, "R10", "irq with enable", irq, 1);
    wr(3'd0, 32'h008);
    idle(4);
    chk(err_flag == 1, "R11", "write without clear bit keeps flag", err_flag, 1);
    wr(3'd0, 32'h108);
    chk(err_flag == 0, "R11", "clear bit clears flag", err_flag, 0);
    chk(irq == 0, "R11", "irq drops after clear", irq, 0);
  endtask

  task automatic t_dma();
    wr(3'd4, 32'h3);
    wr(3'd0, 32'h4);
    chk(dma_req == 1, "R9", "empty fifo requests", dma_req, 1);
    for (int i = 0; i < 3; i++) push(32'h100 + i);
    chk(dma_req == 1, "R9", "level equal to watermark", dma_req, 1);
    push(32'h200);
    chk(dma_req == 0, "R9", "level above watermark", dma_req, 0);
    for (int i = 0; i < 27; i++) push(32'h300 + i);
    chk(fifo_full == 0, "R8", "31 entries not full", fifo_full, 0);
    push(32'h400);
    chk(fifo_full == 1, "R8", "32 entries full", fifo_full, 1);
    wr(3'd0, 32'h0);
    chk(dma_req == 0, "R9", "request off without enable", dma_req, 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    t_reset();
    t_stereo();
    t_mixed();
    t_lock();
    t_underrun();
    t_dma();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule